// File: doc/BRIEF.md
# Serial Keyboard to Key-Matrix Emulator

This block sits between a PS/2 byte receiver and an older computer that expects a passive key matrix. It takes each received byte, tracks the release (0xF0) and extended (0xE0) prefixes, and discards the multi-byte Pause sequence. It looks up the matrix position of each resulting key code and sets or clears one bit of a key-state array.

The host computer scans the array through eight active-low row-select inputs. The block answers on active-low column outputs, the same way a real switch matrix would. A synchronous clear input releases every key and drops any pending prefix. Receiver logic can use it after a framing error.

Top module: `kbmatrix_emu`

## Requirements
- R1: After reset every key is released, and each column output reads 1 for any row selection.
- R2: A byte with bit 7 low, accepted with no prefix pending, presses its mapped key, and the press is visible from the next clock edge. Plain map as (row,col): 12 or 59→(0,0), 1A→(0,1), 22→(0,2), 21→(0,3), 2A→(0,4); 1C→(1,0), 1B→(1,1), 23→(1,2), 2B→(1,3), 34→(1,4); 15→(2,0), 1D→(2,1), 24→(2,2), 2D→(2,3), 2C→(2,4); 16→(3,0), 1E or 72→(3,1), 26→(3,2), 25 or 6B→(3,3), 2E→(3,4); 45 or 70→(4,0), 46→(4,1), 3E or 75→(4,2), 3D→(4,3), 36 or 74→(4,4); 4D→(5,0), 44→(5,1), 43→(5,2), 3C→(5,3), 35→(5,4); 5A→(6,0), 4B→(6,1), 42→(6,2), 3B→(6,3), 33→(6,4); 29→(7,0), 49→(7,1), 3A→(7,2), 31→(7,3), 32→(7,4).
- R3: A 0xF0 byte makes the next key code release its key (clear its bit) instead of pressing it.
- R4: A 0xE0 byte selects the extended map for the next key code: 5A→(6,0), 75→(4,3), 74→(4,2), 72→(4,4), 6B→(3,4). Every other extended code is unmapped. In particular, extended 70 changes nothing, while plain 70 maps to (4,0).
- R5: A 0xE1 byte with no prefix pending starts a skip of the next seven accepted bytes, whatever their values. The full Pause sequence E1 14 77 E1 F0 14 F0 77 therefore changes no key, and the byte after it is decoded normally.
- R6: The Print Screen make sequence E0 12 E0 7C and its break sequence E0 F0 7C E0 F0 12 change no key.
- R7: An unmapped key code changes no key but still clears any pending release or extended prefix.
- R8: A byte with bit 7 high other than F0, E0 or E1 changes no key and clears any pending prefix.
- R9: Column output c is 0 exactly when some selected row (row-select bit low) holds a pressed key in column c. With several rows selected, this is the AND of their active-low bits. With no row selected, all outputs are 1.
- R10: Clear, sampled at a clock edge, releases every key and cancels pending prefixes and any Pause skip. It wins over a byte accepted at the same edge.
- R11: Prefix flags are cleared after every key code, so 0xF0 affects only the one key code that follows it.
- R12: Byte data is ignored while the byte-valid input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | Qualifies byte_data for one cycle |
| byte_data | input | 8 | Received keyboard byte |
| clear_all | input | 1 | Synchronous release of all keys and prefix state |
| row_sel_n | input | 8 | Active-low row selects from the host |
| col_out_n | output | 5 | Active-low column sense outputs |

## Verification
Assertions check on every cycle that:
- the prefix flags drop after each key code;
- no key event leaves the decoder during a Pause skip;
- clear empties the array by the next edge;
- a press lands in its mapped bit;
- the array holds still when no event arrives;
- an idle scan reads all ones.

Only the bench scenarios can show that the map table is right, and that prefix ordering works across whole byte sequences such as Pause and Print Screen. The same holds for unmapped and stray high bytes flushing pending prefixes, and for multi-row scans combining several pressed keys.

// File: rtl/kbm_pkg.sv
// Shared constants and types for the key-matrix emulator.
// Assumes a host matrix of eight rows and five columns.
package kbm_pkg;
    localparam int KBM_ROWS    = 8;
    localparam int KBM_COLS    = 5;
    localparam int PAUSE_BYTES = 8;

    // One decoded key code with the prefix flags that applied to it.
    typedef struct packed {
        logic       valid;
        logic       release_key;
        logic       ext;
        logic [6:0] code;
    } key_evt_t;
endpackage

// File: rtl/kbm_prefix_fsm.sv
// Prefix decoder: tracks release/extended flags and skips the Pause
// sequence, and emits one key event per accepted key code.
// Assumes one byte per valid cycle; the event is combinational.
module kbm_prefix_fsm
    import kbm_pkg::*;
#(
    parameter int PAUSE_LEN = PAUSE_BYTES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_all,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    output key_evt_t   evt
);
    localparam int SKIP_W = $clog2(PAUSE_LEN);

    logic              rel_q;
    logic              ext_q;
    logic [SKIP_W-1:0] skip_q;
    logic              in_skip;

    assign in_skip = (skip_q != '0);

    // Build the key event from the current byte and pending flags.
    always_comb begin
        evt.valid       = byte_valid && !in_skip && !byte_data[7];
        evt.release_key = rel_q;
        evt.ext         = ext_q;
        evt.code        = byte_data[6:0];
    end

    // Update prefix flags and the Pause skip counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) begin
            rel_q  <= 1'b0;
            ext_q  <= 1'b0;
            skip_q <= '0;
        end else if (byte_valid) begin
            if (in_skip) begin
                skip_q <= skip_q - 1'b1;
            end else if (!byte_data[7]) begin
                rel_q <= 1'b0;
                ext_q <= 1'b0;
            end else begin
                case (byte_data)
                    8'hF0:   rel_q <= 1'b1;
                    8'hE0:   ext_q <= 1'b1;
                    8'hE1: begin
                        rel_q  <= 1'b0;
                        ext_q  <= 1'b0;
                        skip_q <= SKIP_W'(PAUSE_LEN - 1);
                    end
                    default: begin
                        rel_q <= 1'b0;
                        ext_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    // R11: flags are gone after a key code is handled.
    p_flags_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !in_skip && !byte_data[7] && !clear_all) |=> (!rel_q && !ext_q));

    // R5: no key event escapes while a Pause skip is running.
    p_pause_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_skip |-> !evt.valid);

    // R10: clear returns the decoder to idle.
    p_clear_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (skip_q == '0 && !rel_q && !ext_q));
endmodule

// File: rtl/kbm_keymap.sv
// Combinational key-code to matrix-position lookup.
// Assumes the 8-row by 5-column host layout; hit is low for unmapped codes.
module kbm_keymap
    import kbm_pkg::*;
#(
    parameter int ROW_W = $clog2(KBM_ROWS),
    parameter int COL_W = $clog2(KBM_COLS)
) (
    input  logic             ext,
    input  logic [6:0]       code,
    output logic             hit,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col
);
    localparam int ENT_W = 1 + ROW_W + COL_W;

    logic [ENT_W-1:0] ent;

    function automatic logic [ENT_W-1:0] at(input int r, input int c);
        return {1'b1, ROW_W'(r), COL_W'(c)};
    endfunction

    // Look up {extended, code}; extended codes have bit 7 set.
    always_comb begin
        ent = '0;
        case ({ext, code})
            8'h12, 8'h59:        ent = at(0, 0);
            8'h1A:               ent = at(0, 1);
            8'h22:               ent = at(0, 2);
            8'h21:               ent = at(0, 3);
            8'h2A:               ent = at(0, 4);
            8'h1C:               ent = at(1, 0);
            8'h1B:               ent = at(1, 1);
            8'h23:               ent = at(1, 2);
            8'h2B:               ent = at(1, 3);
            8'h34:               ent = at(1, 4);
            8'h15:               ent = at(2, 0);
            8'h1D:               ent = at(2, 1);
            8'h24:               ent = at(2, 2);
            8'h2D:               ent = at(2, 3);
            8'h2C:               ent = at(2, 4);
            8'h16:               ent = at(3, 0);
            8'h1E, 8'h72:        ent = at(3, 1);
            8'h26:               ent = at(3, 2);
            8'h25, 8'h6B:        ent = at(3, 3);
            8'h2E, 8'hEB:        ent = at(3, 4);
            8'h45, 8'h70:        ent = at(4, 0);
            8'h46:               ent = at(4, 1);
            8'h3E, 8'h75, 8'hF4: ent = at(4, 2);
            8'h3D, 8'hF5:        ent = at(4, 3);
            8'h36, 8'h74, 8'hF2: ent = at(4, 4);
            8'h4D:               ent = at(5, 0);
            8'h44:               ent = at(5, 1);
            8'h43:               ent = at(5, 2);
            8'h3C:               ent = at(5, 3);
            8'h35:               ent = at(5, 4);
            8'h5A, 8'hDA:        ent = at(6, 0);
            8'h4B:               ent = at(6, 1);
            8'h42:               ent = at(6, 2);
            8'h3B:               ent = at(6, 3);
            8'h33:               ent = at(6, 4);
            8'h29:               ent = at(7, 0);
            8'h49:               ent = at(7, 1);
            8'h3A:               ent = at(7, 2);
            8'h31:               ent = at(7, 3);
            8'h32:               ent = at(7, 4);
            default:             ent = '0;
        endcase
    end

    assign {hit, row, col} = ent;
endmodule

// File: rtl/kbm_matrix_store.sv
// Key-state array with an active-low row-addressed scan port.
// Assumes at most one update per cycle; clear has priority over updates.
module kbm_matrix_store #(
    parameter int ROWS  = 8,
    parameter int COLS  = 5,
    parameter int ROW_W = $clog2(ROWS),
    parameter int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_all,
    input  logic             upd,
    input  logic             press,
    input  logic [ROW_W-1:0] row_idx,
    input  logic [COL_W-1:0] col_idx,
    input  logic [ROWS-1:0]  row_sel_n,
    output logic [COLS-1:0]  col_out_n
);
    logic [ROWS-1:0][COLS-1:0] pressed;

    // Set or clear one key bit per event; reset and clear release all.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) begin
            pressed <= '0;
        end else if (upd && (int'(row_idx) < ROWS) && (int'(col_idx) < COLS)) begin
            pressed[row_idx][col_idx] <= press;
        end
    end

    // One active-low sense line per column, pulled low by any selected pressed key.
    for (genvar c = 0; c < COLS; c++) begin : g_col
        always_comb begin
            col_out_n[c] = 1'b1;
            for (int r = 0; r < ROWS; r++) begin
                if (!row_sel_n[r] && pressed[r][c]) col_out_n[c] = 1'b0;
            end
        end
    end

    // R10: clear leaves the array empty.
    p_clear_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (pressed == '0));

    // R2: a press event lands in its addressed bit.
    p_press_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && press && !clear_all) |=> pressed[$past(row_idx)][$past(col_idx)]);

    // R7: with no event and no clear, the array holds its state.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !clear_all) |=> $stable(pressed));

    // R9: with no row selected, every column reads released.
    p_idle_scan_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (&row_sel_n) |-> (&col_out_n));
endmodule

// File: rtl/kbmatrix_emu.sv
// Top level: prefix decoder, key map and key-state array in series.
// Assumes bytes come from a receiver that has already framed them.
module kbmatrix_emu
    import kbm_pkg::*;
#(
    parameter int ROWS = KBM_ROWS,
    parameter int COLS = KBM_COLS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            byte_valid,
    input  logic [7:0]      byte_data,
    input  logic            clear_all,
    input  logic [ROWS-1:0] row_sel_n,
    output logic [COLS-1:0] col_out_n
);
    localparam int ROW_W = $clog2(ROWS);
    localparam int COL_W = $clog2(COLS);

    key_evt_t         evt;
    logic             map_hit;
    logic [ROW_W-1:0] map_row;
    logic [COL_W-1:0] map_col;
    logic             upd;

    kbm_prefix_fsm u_prefix (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_all  (clear_all),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .evt        (evt)
    );

    kbm_keymap #(.ROW_W(ROW_W), .COL_W(COL_W)) u_map (
        .ext  (evt.ext),
        .code (evt.code),
        .hit  (map_hit),
        .row  (map_row),
        .col  (map_col)
    );

    // Only mapped key codes reach the array.
    assign upd = evt.valid && map_hit;

    kbm_matrix_store #(.ROWS(ROWS), .COLS(COLS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (clear_all),
        .upd       (upd),
        .press     (!evt.release_key),
        .row_idx   (map_row),
        .col_idx   (map_col),
        .row_sel_n (row_sel_n),
        .col_out_n (col_out_n)
    );
endmodule

// File: tb/kbmatrix_emu_test.sv
`timescale 1ns/1ps
module kbmatrix_emu_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       clear_all = 1'b0;
    logic [7:0] row_sel_n = 8'hFF;
    logic [4:0] col_out_n;

    int tests = 0;
    int fails = 0;

    logic [4:0] exp_m [8];
    bit m_rel, m_ext;
    int m_skip;

    kbmatrix_emu uut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .clear_all(clear_all), .row_sel_n(row_sel_n), .col_out_n(col_out_n)
    );

    always #2 clk = ~clk;

    // Expected map position as row*8+col, or -1 when unmapped.
    function automatic int map_key(bit ext, logic [6:0] code);
        case ({ext, code})
            8'h12, 8'h59: return 0;  8'h1A: return 1;  8'h22: return 2;  8'h21: return 3;  8'h2A: return 4;
            8'h1C: return 8;  8'h1B: return 9;  8'h23: return 10; 8'h2B: return 11; 8'h34: return 12;
            8'h15: return 16; 8'h1D: return 17; 8'h24: return 18; 8'h2D: return 19; 8'h2C: return 20;
            8'h16: return 24; 8'h1E, 8'h72: return 25; 8'h26: return 26; 8'h25, 8'h6B: return 27; 8'h2E, 8'hEB: return 28;
            8'h45, 8'h70: return 32; 8'h46: return 33; 8'h3E, 8'h75, 8'hF4: return 34; 8'h3D, 8'hF5: return 35;
            8'h36, 8'h74, 8'hF2: return 36;
            8'h4D: return 40; 8'h44: return 41; 8'h43: return 42; 8'h3C: return 43; 8'h35: return 44;
            8'h5A, 8'hDA: return 48; 8'h4B: return 49; 8'h42: return 50; 8'h3B: return 51; 8'h33: return 52;
            8'h29: return 56; 8'h49: return 57; 8'h3A: return 58; 8'h31: return 59; 8'h32: return 60;
            default: return -1;
        endcase
    endfunction

    function automatic void model_clear();
        for (int r = 0; r < 8; r++) exp_m[r] = '0;
        m_rel = 0; m_ext = 0; m_skip = 0;
    endfunction

    function automatic void model_byte(logic [7:0] b);
        int p;
        if (m_skip > 0) begin
            m_skip--;
        end else if (!b[7]) begin
            p = map_key(m_ext, b[6:0]);
            if (p >= 0) exp_m[p / 8][p % 8] = !m_rel;
            m_rel = 0; m_ext = 0;
        end else if (b == 8'hF0) m_rel = 1;
        else if (b == 8'hE0) m_ext = 1;
        else if (b == 8'hE1) begin m_skip = 7; m_rel = 0; m_ext = 0; end
        else begin m_rel = 0; m_ext = 0; end
    endfunction

    function automatic logic [4:0] exp_scan(logic [7:0] sel_n);
        logic [4:0] acc = '0;
        for (int r = 0; r < 8; r++) if (!sel_n[r]) acc |= exp_m[r];
        return ~acc;
    endfunction

    task automatic push(logic [7:0] b);
        @(negedge clk);
        byte_data = b; byte_valid = 1'b1;
        @(negedge clk);
        byte_valid = 1'b0;
        model_byte(b);
    endtask

    task automatic check_sel(logic [7:0] sel_n, string req);
        logic [4:0] e;
        row_sel_n = sel_n;
        #0.5;
        e = exp_scan(sel_n);
        tests++;
        if (col_out_n !== e) begin
            fails++;
            $display("FAIL %s sel=%b: got %b expected %b", req, sel_n, col_out_n, e);
        end
    endtask

    task automatic check_rows(string req);
        for (int r = 0; r < 8; r++) check_sel(~(8'b1 << r), req);
        row_sel_n = 8'hFF;
    endtask

    task automatic run_seq(logic [7:0] seq[$]);
        foreach (seq[i]) push(seq[i]);
    endtask

    logic [7:0] pool [20] = '{8'h1C, 8'h1A, 8'h12, 8'h59, 8'h75, 8'h72, 8'h6B, 8'h74, 8'h70, 8'h5A,
                              8'h29, 8'h32, 8'h4D, 8'h35, 8'h2E, 8'h16, 8'h7C, 8'h0E, 8'h14, 8'h33};

    initial begin
        void'($urandom(32'd1234));
        model_clear();
        repeat (3) @(negedge clk);
        check_rows("R1");                 // reset state
        check_sel(8'h00, "R1");
        rst_n = 1'b1;
        @(negedge clk);

        push(8'h1C); check_rows("R2");    // A press
        push(8'h32); check_rows("R2");
        push(8'hF0); push(8'h1C); check_rows("R3");
        push(8'h75); push(8'hE0); push(8'h75); check_rows("R4");
        push(8'hE0); push(8'h70); check_rows("R4"); // extended 70 unmapped
        push(8'h70); check_rows("R4");
        push(8'hF0); push(8'h1C); push(8'h1C); check_rows("R11");
        push(8'hF0); push(8'h0E); push(8'h1C); check_rows("R7");
        push(8'hE0); push(8'h0E); push(8'h6B); check_rows("R7");
        push(8'hF0); push(8'hFA); push(8'h1C); check_rows("R8");
        run_seq('{8'hE1, 8'h14, 8'h77, 8'hE1, 8'hF0, 8'h14, 8'hF0, 8'h77}); check_rows("R5");
        push(8'hF0); push(8'h1C); check_rows("R5");
        run_seq('{8'hE0, 8'h12, 8'hE0, 8'h7C}); check_rows("R6");
        run_seq('{8'hE0, 8'hF0, 8'h7C, 8'hE0, 8'hF0, 8'h12}); check_rows("R6");

        // R12: data without valid is ignored
        @(negedge clk); byte_data = 8'h1A;
        repeat (4) @(negedge clk);
        check_rows("R12");

        // R9: multi-row scans
        check_sel(8'h00, "R9");
        check_sel(8'h6E, "R9");
        check_sel(8'hFF, "R9");

        // R10: clear beats a simultaneous byte
        @(negedge clk); byte_data = 8'h22; byte_valid = 1'b1; clear_all = 1'b1;
        @(negedge clk); byte_valid = 1'b0; clear_all = 1'b0; model_clear();
        check_rows("R10");
        push(8'hF0);
        @(negedge clk); clear_all = 1'b1; @(negedge clk); clear_all = 1'b0; model_clear();
        push(8'h1C); check_rows("R10");
        push(8'hE1); push(8'h14);
        @(negedge clk); clear_all = 1'b1; @(negedge clk); clear_all = 1'b0; model_clear();
        push(8'h29); check_rows("R10");

        // Random mix against the model
        for (int it = 0; it < 400; it++) begin
            int k = $urandom % 100;
            if (k < 8) run_seq('{8'hE1, 8'h14, 8'h77, 8'hE1, 8'hF0, 8'h14, 8'hF0, 8'h77});
            else if (k < 18) push(8'($urandom));
            else begin
                if (($urandom % 100) < 20) push(8'hE0);
                if (($urandom % 100) < 40) push(8'hF0);
                push(pool[$urandom % 20]);
            end
            check_sel(~(8'b1 << ($urandom % 8)), "R2");
            check_sel(8'($urandom), "R9");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule